// File: doc/BRIEF.md
# Universal Multiply-Add Functional Unit

This block is a 32-bit compound functional unit for a tile of a statically scheduled spatial array. It brings a fused multiply-add/subtract and a simple arithmetic, logic, shift, compare and select unit together behind one shared result port. It takes four word operands and a 4-bit opcode. It can accept a new operation on every clock, and it produces one result per clock.

The multiply path is split into two register stages. The first stage forms the low word of the product. The second stage adds or subtracts the addend. Operations that are not multiplies finish their arithmetic in the first cycle. A result register delays them so that every operation has the same two-cycle latency. Results therefore leave in issue order and can never collide at the output. A valid bit travels beside each operation. When no operation is issued, the output register keeps its last value.

Top module: `ufu_madd_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_data` are cleared to zero on that edge.
- R2: An operation issued with `in_valid` high at rising edge t gives `out_valid` high after edge t+2. An edge with `in_valid` low gives `out_valid` low after edge t+2, and at that point `out_data` keeps its previous value.
- R3: Opcode 0 returns a+b, opcode 1 returns a-b and opcode 2 returns 0-a. All three wrap modulo 2^32.
- R4: Opcode 3 returns a AND b, opcode 4 returns a OR b and opcode 5 returns a XOR b.
- R5: The shift amount is b[4:0]. Opcode 6 shifts a left, opcode 7 shifts a right logically and opcode 8 shifts a right arithmetically.
- R6: Opcode 13 returns 1 if a is less than b as signed numbers and 0 otherwise. Opcode 14 returns 1 if a equals b and 0 otherwise.
- R7: Opcode 9 returns a when d[0] is 1 and b when d[0] is 0. The other bits of d are ignored.
- R8: Opcode 10 returns the low 32 bits of a*b.
- R9: Opcode 11 returns the low 32 bits of a*b+c. Opcode 12 returns the low 32 bits of a*b-c.
- R10: Opcode 15 is not assigned and returns zero, with `out_valid` high.
- R11: Operations of any mix of types, issued on consecutive cycles, each give their own correct result in issue order, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for this cycle's operation |
| in_op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand and shift amount |
| opnd_c | input | 32 | Addend for the multiply-add and multiply-subtract operations |
| opnd_d | input | 32 | Select predicate in bit 0 |
| out_valid | output | 1 | Result valid flag |
| out_data | output | 32 | Result word |

## Verification
The bench issues a multiply followed straight away by single-cycle operations, and the reverse. A design whose latencies did not match would deliver results out of order, or two results in the same slot. Other directed cases cover the corners. Sums that overflow show whether arithmetic wraps. A shift by 31 and an arithmetic right shift of a negative word show whether shifts are handled correctly. A signed comparison of 0x80000000 against 1 exposes a compare done as unsigned. A multiply of 0xFFFFFFFF by itself and a multiply-add that wraps past 2^32 expose a truncation applied in the wrong place. A select whose predicate word is even but non-zero exposes a select that tests more than bit 0. Bubbles placed between issues show whether the valid flag is generated from the operation rather than from the clock, and whether the result word is held during a bubble.

// File: rtl/ufu_pkg.sv
package ufu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_NEG  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_SRA  = 4'd8,
    OP_SEL  = 4'd9,
    OP_MUL  = 4'd10,
    OP_MADD = 4'd11,
    OP_MSUB = 4'd12,
    OP_SLT  = 4'd13,
    OP_EQ   = 4'd14,
    OP_NONE = 4'd15
  } ufu_op_e;

  function automatic logic is_mac_op(input ufu_op_e op);
    return (op == OP_MUL) || (op == OP_MADD) || (op == OP_MSUB);
  endfunction

endpackage

// File: rtl/ufu_mac_pipe.sv
module ufu_mac_pipe
  import ufu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  ufu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);

  // Only the low word of the product survives, so the multiplier is cut to W bits
  logic [W-1:0] prod_lo;
  logic [W-1:0] prod_q;
  logic [W-1:0] addend_q;
  logic         neg_q;

  assign prod_lo = a * b;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q   <= '0;
      addend_q <= '0;
      neg_q    <= 1'b0;
    end else if (load) begin
      prod_q   <= prod_lo;
      addend_q <= (op == OP_MUL) ? '0 : c;
      neg_q    <= (op == OP_MSUB);
    end
  end

  // Second stage: the accumulate sits after the product register
  assign sum = neg_q ? (prod_q - addend_q) : (prod_q + addend_q);

  p_madd_sum_r9: assert property (@(posedge clk) disable iff (rst)
    (load && op == OP_MADD) |=> (sum == $past(a * b + c)));

  p_msub_sum_r9: assert property (@(posedge clk) disable iff (rst)
    (load && op == OP_MSUB) |=> (sum == $past(a * b - c)));

endmodule

// File: rtl/ufu_simple_path.sv
module ufu_simple_path
  import ufu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  ufu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] d,
  output logic [W-1:0] res_q
);

  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  logic [W-1:0]    res_d;
  logic            unused_pred_hi;

  assign sh             = b[SH_W-1:0];
  assign unused_pred_hi = ^d[W-1:1];

  always_comb begin
    case (op)
      OP_ADD:  res_d = a + b;
      OP_SUB:  res_d = a - b;
      OP_NEG:  res_d = '0 - a;
      OP_AND:  res_d = a & b;
      OP_OR:   res_d = a | b;
      OP_XOR:  res_d = a ^ b;
      OP_SHL:  res_d = a << sh;
      OP_SHR:  res_d = a >> sh;
      OP_SRA:  res_d = W'($signed(a) >>> sh);
      OP_SEL:  res_d = d[0] ? a : b;
      OP_SLT:  res_d = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_EQ:   res_d = {{(W-1){1'b0}}, (a == b)};
      default: res_d = '0;
    endcase
  end

  // Delay register: gives the single-cycle results the same latency as the multiply path
  always_ff @(posedge clk) begin
    if (rst)       res_q <= '0;
    else if (load) res_q <= res_d;
  end

  p_select_steer_r7: assert property (@(posedge clk) disable iff (rst)
    (load && op == OP_SEL) |=> (res_q == ($past(d[0]) ? $past(a) : $past(b))));

  p_shift_left_r5: assert property (@(posedge clk) disable iff (rst)
    (load && op == OP_SHL) |=> (res_q == ($past(a) << $past(b[SH_W-1:0]))));

endmodule

// File: rtl/ufu_madd_unit.sv
module ufu_madd_unit
  import ufu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_c,
  input  logic [W-1:0] opnd_d,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  ufu_op_e      op;
  logic         issue_mac;
  logic         v1_q;
  logic         mac1_q;
  logic [W-1:0] mac_sum;
  logic [W-1:0] simple_res;

  assign op        = ufu_op_e'(in_op);
  assign issue_mac = is_mac_op(op);

  ufu_mac_pipe #(.W(W)) u_mac (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid && issue_mac),
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .c    (opnd_c),
    .sum  (mac_sum)
  );

  ufu_simple_path #(.W(W)) u_simple (
    .clk   (clk),
    .rst   (rst),
    .load  (in_valid && !issue_mac),
    .op    (op),
    .a     (opnd_a),
    .b     (opnd_b),
    .d     (opnd_d),
    .res_q (simple_res)
  );

  // Stage 1 tag: valid flag and which path holds the result
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      mac1_q <= 1'b0;
    end else begin
      v1_q   <= in_valid;
      mac1_q <= issue_mac;
    end
  end

  // Stage 2: one shared output register, loaded only for a valid operation
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) out_data <= mac1_q ? mac_sum : simple_res;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_issue_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);

  p_bubble_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 (!out_valid && $stable(out_data)));

  p_mul_low_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_MUL) |=> ##1 (out_data == $past(opnd_a * opnd_b, 2)));

  p_unassigned_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_NONE) |=> ##1 (out_data == '0));

endmodule

// File: tb/ufu_madd_unit_test.sv
module ufu_madd_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, opnd_d = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Expected-value pipeline: slot issued one and two cycles ago
  logic        hv0 = 0, hv1 = 0;
  logic [31:0] hd0 = '0, hd1 = '0, last_d = '0;
  string       hr0 = "R2", hr1 = "R2";
  logic [31:0] rng = 32'h1badcafe;

  always #10 clk = ~clk;  // 50 MHz

  ufu_madd_unit #(.W(32)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_d(opnd_d),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c,
                                            input logic [31:0] d);
    logic [31:0] p;
    int sh;
    p  = a * b;
    sh = int'(b[4:0]);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return 32'd0 - a;
      4'd3:  return a & b;
      4'd4:  return a | b;
      4'd5:  return a ^ b;
      4'd6:  return a << sh;
      4'd7:  return a >> sh;
      4'd8:  return 32'($signed(a) >>> sh);
      4'd9:  return d[0] ? a : b;
      4'd10: return p;
      4'd11: return p + c;
      4'd12: return p - c;
      4'd13: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd14: return (a == b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2:   return "R3";
      4'd3, 4'd4, 4'd5:   return "R4";
      4'd6, 4'd7, 4'd8:   return "R5";
      4'd13, 4'd14:       return "R6";
      4'd9:               return "R7";
      4'd10:              return "R8";
      4'd11, 4'd12:       return "R9";
      default:            return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // One issue slot: check the result of the slot two cycles back, then drive a new one
  task automatic slot(input logic v, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    if (hv1) begin
      check(out_valid === 1'b1, {hr1, " valid"}, 32'(out_valid), 32'd1);
      check(out_data === hd1, {hr1, " R11 data"}, out_data, hd1);
      last_d = hd1;
    end else begin
      check(out_valid === 1'b0, "R2 bubble valid", 32'(out_valid), 32'd0);
      check(out_data === last_d, "R2 bubble hold", out_data, last_d);
    end
    hv1 = hv0; hd1 = hd0; hr1 = hr0;
    hv0 = v;
    hd0 = ref_model(op, a, b, c, d);
    hr0 = req_of(op);
    in_valid = v; in_op = op;
    opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h0000_0002;
    vals[3] = 32'hFFFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h7FFF_FFFF;
    vals[6] = 32'h0000_001F; vals[7] = 32'h1234_5678;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: cleared state right after reset
    check(out_valid === 1'b0, "R1 valid", 32'(out_valid), 32'd0);
    check(out_data === 32'd0, "R1 data", out_data, 32'd0);

    // Directed corner cases, back to back with mixed latencies
    slot(1, 4'd0,  32'h7FFF_FFFF, 32'd1, 0, 0);          // R3 wrap
    slot(1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);  // R8 low word = 1
    slot(1, 4'd1,  32'd0, 32'd1, 0, 0);                  // R3
    slot(1, 4'd2,  32'h8000_0000, 0, 0, 0);              // R3 negate
    slot(1, 4'd11, 32'h0001_0000, 32'h0001_0000, 32'd5, 0); // R9 wraps to 5
    slot(1, 4'd12, 32'd0, 32'd9, 32'd1, 0);              // R9 0-1
    slot(1, 4'd6,  32'd1, 32'd31, 0, 0);                 // R5 shift 31
    slot(1, 4'd7,  32'h8000_0000, 32'hFFFF_FFE0, 0, 0);  // R5 amount 0 from low bits
    slot(1, 4'd8,  32'h8000_0000, 32'd4, 0, 0);          // R5 sign fill
    slot(1, 4'd13, 32'h8000_0000, 32'd1, 0, 0);          // R6 signed true
    slot(1, 4'd13, 32'd1, 32'h8000_0000, 0, 0);          // R6 signed false
    slot(1, 4'd14, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0);  // R6 equal
    slot(1, 4'd9,  32'hAAAA_AAAA, 32'h5555_5555, 0, 32'h1); // R7 take a
    slot(1, 4'd9,  32'hAAAA_AAAA, 32'h5555_5555, 0, 32'hFFFF_FFFE); // R7 take b
    slot(1, 4'd15, 32'h1234_5678, 32'h1, 32'h2, 32'h3);  // R10 zero
    slot(0, 4'd0,  32'h1, 32'h1, 0, 0);                  // R2 bubble
    slot(1, 4'd11, 32'd3, 32'd4, 32'd5, 0);              // R9 after bubble
    slot(0, 4'd10, 32'h7, 32'h7, 0, 0);                  // R2 bubble after mac
    slot(1, 4'd3,  32'hF0F0_F0F0, 32'hFF00_FF00, 0, 0);  // R4
    slot(1, 4'd4,  32'hF0F0_F0F0, 32'h0F0F_0000, 0, 0);  // R4
    slot(1, 4'd5,  32'hFFFF_0000, 32'hF0F0_F0F0, 0, 0);  // R4

    // Near-exhaustive sweep: every opcode over corner operand pairs (R11)
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          slot(1, 4'(op), vals[ia], vals[ib], vals[(ia + ib) % 8], vals[(ia * 3 + ib) % 8]);

    // Random mixed stream with occasional bubbles
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb, rc, rd;
      logic [3:0]  ro;
      logic        rv;
      rng = next_rng(rng); ra = rng;
      rng = next_rng(rng); rb = rng;
      rng = next_rng(rng); rc = rng;
      rng = next_rng(rng); rd = rng;
      ro = rd[7:4];
      rv = (rd[11:9] != 3'd0);
      slot(rv, ro, ra, rb, rc, rd);
    end

    // Drain the pipeline
    slot(0, 0, 0, 0, 0, 0);
    slot(0, 0, 0, 0, 0, 0);
    slot(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule